// File: doc/BRIEF.md
# Period timer with prescale and postscale

This block is an 8-bit up-counter that advances on a slow tick supplied as a clock-enable, normally one system clock in four. A prescaler of 1, 4 or 16 sits in front of the counter. When the counter has reached the value held in an 8-bit period register and a prescaled tick arrives, the counter goes back to zero. Each such period match emits a one-cycle pulse that a PWM unit can use as its time base.

Period matches are counted by a 4-bit postscaler. When a programmed number of matches has been counted, a sticky interrupt flag is set. Software reaches the counter, the period register, an 8-bit control register and the flag through a small register port. The port has a two-bit address, a write strobe and a combinational read path.

Top module: `period_timer`

## Requirements
- R1: Address 0 reads and writes the counter and address 1 the period register, both 8 bits wide. Address 3 reads the flag in bit 0 (upper bits 0), and a write there loads the flag from bit 0.
- R2: After a synchronous reset the counter reads 0x00, the period 0xFF, the control register 0x00 and the flag 0. Both scaler counts are also zero.
- R3: Control bit 2 enables the timer. While it is 0 the counter holds its value whatever the tick input does.
- R4: Control bits 1:0 select the prescale ratio. 00 gives one counter step per tick, 01 one step per 4 ticks, and 10 or 11 one step per 16 ticks.
- R5: The first prescaled tick after the counter equals the period register does not increment the counter. Instead the counter is 0 in the following cycle, and match_pulse is high for exactly that cycle.
- R6: Control bits 6:3 hold N. The flag is set on every (N+1)-th period match, so N=0 sets it on every match and N=15 on every sixteenth.
- R7: Once set, the flag stays at 1 until software writes 0 to address 3. A hardware set in the same cycle as that write takes precedence.
- R8: A write to the counter or to the control register clears both the prescaler count and the postscaler count.
- R9: A write to the control register leaves the counter value unchanged.
- R10: Control bit 7 is not stored and always reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Instruction-rate clock-enable that feeds the prescaler |
| reg_addr | input | 2 | Register select: 0 counter, 1 period, 2 control, 3 flag |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| irq_flag | output | 1 | Sticky interrupt flag |
| match_pulse | output | 1 | One-cycle pulse in the cycle the counter returns to 0 after a match |

## Verification
The main path is swept over every prescale code, including the duplicate 11 code, against postscale values 0, 1, 5 and 15 and period values 0, 1 and 3. For each combination the number of ticks until the flag rises is compared with (period+1)·ratio·(N+1). The number of match pulses in that window is compared with N+1.

Because the three factors are multiplied, a wrong ratio, an off-by-one in the period compare and a miscounted postscaler each give a different tick count. These faults are therefore told apart rather than hidden behind one another. Directed sequences write the counter or the control register partway through a prescale or postscale interval, to show that the scaler counts restart. They also show that the count itself survives a control write, and that the flag survives further matches until it is cleared.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;

   // register select codes on the port
   typedef enum logic [1:0] {
      SEL_COUNT  = 2'd0,
      SEL_PERIOD = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_FLAG   = 2'd3
   } tmr_sel_e;

   // control field positions
   localparam int CTL_RUN_BIT  = 2;
   localparam int CTL_PRE_LO   = 0;
   localparam int CTL_POST_LO  = 3;
   localparam int CTL_POST_W   = 4;
   localparam int CTL_STORED_W = 7;

   // terminal count of the prescaler for a 2-bit ratio code
   function automatic logic [3:0] pre_last(input logic [1:0] code);
      logic [3:0] r;
      case (code)
         2'b00:   r = 4'd0;
         2'b01:   r = 4'd3;
         default: r = 4'd15;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       clr,
   input  logic       adv,
   input  logic [1:0] code,
   output logic       ptick
);
   import period_timer_pkg::*;

   generate
      if (PRE_W < 4) begin : g_bad_width
         $error("tmr_prescaler: PRE_W must hold a terminal count of 15");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] last;

   always_comb begin
      last = '0;
      last[3:0] = pre_last(code);
   end

   // a clearing write cancels the tick of its own cycle
   assign ptick = adv && !clr && (cnt_q == last);

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt_q <= '0;
      else if (adv)
         cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
   parameter int POST_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              hit,
   input  logic [POST_W-1:0] limit,
   output logic              roll
);
   generate
      if (POST_W < 1) begin : g_bad_width
         $error("tmr_postscaler: POST_W must be at least 1");
      end
   endgenerate

   logic [POST_W-1:0] cnt_q;

   assign roll = hit && !clr && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt_q <= '0;
      else if (hit)
         cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             ptick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             match_evt
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tmr_count_core: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign match_evt = ptick && !ld && (cnt_q == period);
   assign count     = cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (ld)
         cnt_q <= ld_val;
      else if (ptick)
         cnt_q <= (cnt_q == period) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/period_timer.sv
module period_timer #(
   parameter int CNT_W  = 8,
   parameter int PRE_W  = 4,
   parameter int POST_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             irq_flag,
   output logic             match_pulse
);
   import period_timer_pkg::*;

   localparam int CTL_W = CTL_STORED_W;

   generate
      if (CNT_W != 8) begin : g_bad_cnt
         $error("period_timer: register port is 8 bits wide");
      end
      if (POST_W != CTL_POST_W) begin : g_bad_post
         $error("period_timer: POST_W must match the control field");
      end
   endgenerate

   logic [CNT_W-1:0] period_q;
   logic [CTL_W-1:0] ctrl_q;
   logic             flag_q;
   logic             match_q;
   logic [CNT_W-1:0] count_w;
   logic             wr_count, wr_period, wr_ctrl, wr_flag;
   logic             scaler_clr, run, ptick, match_evt, post_roll;

   assign wr_count   = reg_wr && (reg_addr == SEL_COUNT);
   assign wr_period  = reg_wr && (reg_addr == SEL_PERIOD);
   assign wr_ctrl    = reg_wr && (reg_addr == SEL_CTRL);
   assign wr_flag    = reg_wr && (reg_addr == SEL_FLAG);
   assign scaler_clr = wr_count || wr_ctrl;
   assign run        = ctrl_q[CTL_RUN_BIT];

   tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst   (rst),
      .clr   (scaler_clr),
      .adv   (tick_en && run),
      .code  (ctrl_q[CTL_PRE_LO +: 2]),
      .ptick (ptick)
   );

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst       (rst),
      .ld        (wr_count),
      .ld_val    (reg_wdata),
      .ptick     (ptick),
      .period    (period_q),
      .count     (count_w),
      .match_evt (match_evt)
   );

   tmr_postscaler #(.POST_W(POST_W)) u_post (
      .clk   (clk),
      .rst   (rst),
      .clr   (scaler_clr),
      .hit   (match_evt),
      .limit (ctrl_q[CTL_POST_LO +: POST_W]),
      .roll  (post_roll)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         period_q <= '1;
         ctrl_q   <= '0;
         flag_q   <= 1'b0;
         match_q  <= 1'b0;
      end else begin
         match_q <= match_evt;
         if (wr_period) period_q <= reg_wdata;
         if (wr_ctrl)   ctrl_q   <= reg_wdata[CTL_W-1:0];
         if (post_roll)    flag_q <= 1'b1;
         else if (wr_flag) flag_q <= reg_wdata[0];
      end
   end

   always_comb begin
      unique case (reg_addr)
         SEL_COUNT:  reg_rdata = count_w;
         SEL_PERIOD: reg_rdata = period_q;
         SEL_CTRL:   reg_rdata = {1'b0, ctrl_q};
         default:    reg_rdata = {{(CNT_W-1){1'b0}}, flag_q};
      endcase
   end

   assign irq_flag    = flag_q;
   assign match_pulse = match_q;
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       reg_addr,
   input logic             reg_wr,
   input logic [CNT_W-1:0] reg_rdata,
   input logic             irq_flag,
   input logic             match_pulse,
   input logic [CNT_W-1:0] count_w,
   input logic [CNT_W-1:0] period_q,
   input logic             run
);
   // R5
   match_zero_chk: assert property (@(posedge clk) disable iff (rst)
      match_pulse |-> (count_w == '0) && ($past(count_w) == $past(period_q)));

   // R3
   hold_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!run && !(reg_wr && reg_addr == 2'd0)) |=> $stable(count_w));

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_flag && !(reg_wr && reg_addr == 2'd3)) |=> irq_flag);

   // R9
   ctrl_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == 2'd2) |=> $stable(count_w));

   // R10
   ctrl_msb_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_addr == 2'd2) |-> (reg_rdata[CNT_W-1] == 1'b0));
endmodule

bind period_timer period_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .reg_addr    (reg_addr),
   .reg_wr      (reg_wr),
   .reg_rdata   (reg_rdata),
   .irq_flag    (irq_flag),
   .match_pulse (match_pulse),
   .count_w     (count_w),
   .period_q    (period_q),
   .run         (run)
);

// File: tb/sim_period_timer.sv
module sim_period_timer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_en = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq_flag;
   logic       match_pulse;

   int checks = 0;
   int errors = 0;
   int seen_match = 0;

   always #10 clk = ~clk;

   period_timer u0 (
      .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_flag(irq_flag), .match_pulse(match_pulse)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // one instruction-rate tick, then three idle clocks
   task automatic tick();
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      if (match_pulse) seen_match++;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v;
      int n;
      int ratio;
      int exp_n;
      int posts[4] = '{0, 1, 5, 15};
      int pers[3]  = '{0, 1, 3};

      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R2 reset values
      rd(2'd0, v); chk("R2 counter", v, 0);
      rd(2'd1, v); chk("R2 period", v, 255);
      rd(2'd2, v); chk("R2 control", v, 0);
      rd(2'd3, v); chk("R2 flag", v, 0);

      // R1 register access
      wr(2'd0, 8'hA5); rd(2'd0, v); chk("R1 counter rw", v, 8'hA5);
      wr(2'd1, 8'h3C); rd(2'd1, v); chk("R1 period rw", v, 8'h3C);

      // R10 bit 7 not stored
      wr(2'd2, 8'hFF); rd(2'd2, v); chk("R10 ctrl msb", v, 8'h7F);

      // R3 timer off holds counter
      wr(2'd2, 8'h00); wr(2'd0, 8'h10);
      repeat (5) tick();
      rd(2'd0, v); chk("R3 off hold", v, 8'h10);

      // R9 control write keeps count
      wr(2'd0, 8'h33); wr(2'd2, 8'h05);
      rd(2'd0, v); chk("R9 ctrl keeps count", v, 8'h33);

      // R8 counter write clears prescaler (ratio 4)
      wr(2'd1, 8'hFF); wr(2'd2, 8'h05); wr(2'd0, 8'h00);
      repeat (2) tick();
      wr(2'd0, 8'h07);
      repeat (3) tick();
      rd(2'd0, v); chk("R8 pre cleared, 3 ticks", v, 7);
      tick();
      rd(2'd0, v); chk("R8 pre cleared, 4th tick", v, 8);

      // R8 control write clears postscaler (2 matches, period 0, ratio 1)
      wr(2'd3, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h0C); wr(2'd0, 8'h00);
      tick(); chk("R8 first match no flag", irq_flag, 0);
      wr(2'd2, 8'h0C);
      tick(); chk("R8 post cleared no flag", irq_flag, 0);
      tick(); chk("R8 flag after two matches", irq_flag, 1);

      // R7 software set/clear and stickiness
      wr(2'd2, 8'h00); wr(2'd3, 8'h00); chk("R7 clear", irq_flag, 0);
      wr(2'd3, 8'h01); chk("R7 set", irq_flag, 1);
      rd(2'd3, v); chk("R1 flag read", v, 1);
      wr(2'd3, 8'h00); chk("R7 clear again", irq_flag, 0);

      // R4 R5 R6 sweep
      foreach (posts[i]) foreach (pers[j]) for (int s = 0; s < 4; s++) begin
         ratio = (s == 0) ? 1 : (s == 1) ? 4 : 16;
         exp_n = (pers[j] + 1) * ratio * (posts[i] + 1);
         wr(2'd2, 8'h00);
         wr(2'd3, 8'h00);
         wr(2'd1, pers[j][7:0]);
         wr(2'd0, 8'h00);
         wr(2'd2, 8'((posts[i] << 3) | 4 | s));
         seen_match = 0;
         n = 0;
         while (!irq_flag && n < 3000) begin
            tick();
            n++;
         end
         chk($sformatf("R4 R6 ticks s%0d n%0d p%0d", s, posts[i], pers[j]), n, exp_n);
         chk("R5 R6 match pulses", seen_match, posts[i] + 1);
         rd(2'd0, v); chk("R5 counter wrapped", v, 0);
         tick();
         chk("R7 flag sticky", irq_flag, 1);
      end

      wr(2'd2, 8'h00);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule